// File: doc/BRIEF.md
# Lane-Partitioned Vector Integer ALU with Register Bank

This block holds a bank of 32 vector registers, each 128 bits wide, and a single integer datapath that applies one operation to every lane of two vectors in the same cycle. A two-bit size field sets the lane width. The 128 bits are then treated as sixteen 8-bit, eight 16-bit, four 32-bit or two 64-bit independent integers. One adder array is split at run time into these lanes by cutting the carry chain wherever a lane starts. A sign flag selects a two's-complement or an unsigned view of the lanes, and only the ordering operations depend on it.

Each cycle the two read ports show the registers named by the two source indices. The operation result is formed combinationally from those two values. When the issue strobe is high, the destination register takes either the operation result or an immediate vector at the next rising clock edge. A read of the destination in that same cycle still returns the old contents.

Top module: `vlane_alu_top`

## Requirements
- R1: After reset every one of the 32 registers reads as zero on both read ports.
- R2: With issue high and op code 100 (load), the destination register holds the immediate vector from the next clock edge on.
- R3: Read ports and the result output follow the source indices combinationally. A register written at a clock edge shows its old value in the issuing cycle and its new value from the following cycle.
- R4: Op code 000 (add) adds each lane modulo 2^width, and no carry crosses a lane boundary. The size field codes lanes as 00 = 8 bit, 01 = 16 bit, 10 = 32 bit and 11 = 64 bit, with lane k occupying bits [k*w +: w].
- R5: Op code 001 (subtract) forms A minus B in each lane modulo 2^width, and no borrow crosses a lane boundary.
- R6: With the sign flag low, op code 010 (min) gives the unsigned smaller lane and op code 011 (max) gives the unsigned larger lane.
- R7: With the sign flag high, min and max compare each lane as a two's-complement number.
- R8: Add and subtract give the same bits whatever the sign flag is.
- R9: While issue is low no register changes, whatever the op code and destination are.
- R10: Op codes 101, 110 and 111 write nothing, even with issue high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Perform the write selected by op this cycle |
| op | input | 3 | 000 add, 001 sub, 010 min, 011 max, 100 load immediate, others no write |
| lane_sz | input | 2 | Lane width code: 00 = 8, 01 = 16, 10 = 32, 11 = 64 bits |
| sgn | input | 1 | Lanes compared as two's-complement when high |
| src_a | input | 5 | Index of register on read port A |
| src_b | input | 5 | Index of register on read port B |
| dst | input | 5 | Index of register written |
| imm | input | 128 | Vector written by the load op |
| vec_a | output | 128 | Contents of register src_a |
| vec_b | output | 128 | Contents of register src_b |
| result | output | 128 | Lane-wise result of op on vec_a and vec_b |

## Verification
The bench goes after lane edges with all-ones plus one and zero minus one patterns at every lane size. A design that leaks a carry or borrow across a lane would corrupt the next lane's low bit. It pairs 0x80-style and 0x7F-style lanes under both sign settings, so a min/max that ignores the sign flag, or a size decode that is off by one, picks the wrong operand. It reads a destination in the cycle it is written and again one cycle later, which catches a write-through bank or a late write. Idle and reserved-code writes are followed by reads that show whether anything was written by mistake.

// File: rtl/vlane_pkg.sv
package vlane_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_MIN  = 3'b010,
    OP_MAX  = 3'b011,
    OP_LOAD = 3'b100
  } vop_e;
endpackage

// File: rtl/vlane_bank.sv
module vlane_bank #(
  parameter int W  = 128,
  parameter int N  = 32,
  parameter int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_a_idx,
  input  logic [AW-1:0] rd_b_idx,
  output logic [W-1:0]  rd_a_val,
  output logic [W-1:0]  rd_b_val,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [W-1:0]  wr_val
);
  logic [W-1:0] regs [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic ent_en;
    assign ent_en = wr_en && (wr_idx == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      regs[i] <= '0;
      else if (ent_en) regs[i] <= wr_val;
    end
  end

  assign rd_a_val = regs[rd_a_idx];
  assign rd_b_val = regs[rd_b_idx];
endmodule

// File: rtl/vlane_addsub.sv
module vlane_addsub #(
  parameter int W   = 128,
  parameter int CW  = 8,
  parameter int SZW = 2
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           sub,
  input  logic [SZW-1:0] lane_sz,
  output logic [W-1:0]   y
);
  localparam int NCH = W / CW;
  localparam int IW  = $clog2(NCH);

  logic [IW-1:0] lane_mask;
  assign lane_mask = (IW'(1) << lane_sz) - IW'(1);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic          brk;
    logic          cin;
    logic          co;
    logic [CW:0]   s;
    logic [CW-1:0] bx;
    assign brk = ((IW'(i) & lane_mask) == '0);
    if (i == 0) begin : g_first
      assign cin = sub;
    end else begin : g_rest
      assign cin = brk ? sub : g_ch[i-1].co;
    end
    assign bx = b[i*CW +: CW] ^ {CW{sub}};
    assign s  = {1'b0, a[i*CW +: CW]} + {1'b0, bx} + {{CW{1'b0}}, cin};
    assign co = s[CW];
    assign y[i*CW +: CW] = s[CW-1:0];
  end
endmodule

// File: rtl/vlane_minmax.sv
module vlane_minmax #(
  parameter int W   = 128,
  parameter int CW  = 8,
  parameter int SZW = 2,
  parameter int NSZ = 1 << SZW
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           sgn,
  input  logic           take_max,
  input  logic [SZW-1:0] lane_sz,
  output logic [W-1:0]   y
);
  logic [W-1:0] per_sz [NSZ];

  for (genvar s = 0; s < NSZ; s++) begin : g_sz
    localparam int LW = CW << s;
    localparam int NL = W / LW;
    for (genvar l = 0; l < NL; l++) begin : g_ln
      logic [LW-1:0] xa, xb;
      logic          lt;
      assign xa = a[l*LW +: LW];
      assign xb = b[l*LW +: LW];
      assign lt = sgn ? ($signed(xa) < $signed(xb)) : (xa < xb);
      assign per_sz[s][l*LW +: LW] = (lt ^ take_max) ? xa : xb;
    end
  end

  assign y = per_sz[lane_sz];
endmodule

// File: rtl/vlane_alu_top.sv
module vlane_alu_top #(
  parameter int VEC_W  = 128,
  parameter int NREGS  = 32,
  parameter int CHUNK  = 8,
  parameter int SZ_W   = 2,
  parameter int IDX_W  = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [2:0]       op,
  input  logic [SZ_W-1:0]  lane_sz,
  input  logic             sgn,
  input  logic [IDX_W-1:0] src_a,
  input  logic [IDX_W-1:0] src_b,
  input  logic [IDX_W-1:0] dst,
  input  logic [VEC_W-1:0] imm,
  output logic [VEC_W-1:0] vec_a,
  output logic [VEC_W-1:0] vec_b,
  output logic [VEC_W-1:0] result
);
  import vlane_pkg::*;

  logic [VEC_W-1:0] as_y, mm_y, wr_val;
  logic             wr_en, is_ord, is_write;

  vlane_bank #(.W(VEC_W), .N(NREGS), .AW(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(src_a), .rd_b_idx(src_b),
    .rd_a_val(vec_a), .rd_b_val(vec_b),
    .wr_en(wr_en), .wr_idx(dst), .wr_val(wr_val)
  );

  vlane_addsub #(.W(VEC_W), .CW(CHUNK), .SZW(SZ_W)) u_addsub (
    .a(vec_a), .b(vec_b), .sub(op == OP_SUB), .lane_sz(lane_sz), .y(as_y)
  );

  vlane_minmax #(.W(VEC_W), .CW(CHUNK), .SZW(SZ_W)) u_minmax (
    .a(vec_a), .b(vec_b), .sgn(sgn), .take_max(op == OP_MAX),
    .lane_sz(lane_sz), .y(mm_y)
  );

  always_comb begin
    is_ord   = (op == OP_MIN) || (op == OP_MAX);
    is_write = (op <= OP_LOAD);
    result   = is_ord ? mm_y : as_y;
    wr_val   = (op == OP_LOAD) ? imm : result;
    wr_en    = issue && is_write;
  end
endmodule

// File: rtl/vlane_alu_chk.sv
module vlane_alu_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         issue,
  input logic [2:0]   op,
  input logic [1:0]   lane_sz,
  input logic         sgn,
  input logic [4:0]   src_a,
  input logic [4:0]   dst,
  input logic [127:0] imm,
  input logic [127:0] vec_a,
  input logic [127:0] vec_b,
  input logic [127:0] result
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_load_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(issue) && $past(op) == 3'b100 && src_a == $past(dst))
      |-> vec_a == $past(imm));

  assert_alu_writeback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(issue) && $past(op) < 3'b100 && src_a == $past(dst))
      |-> vec_a == $past(result));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(issue) && src_a == $past(src_a)) |-> vec_a == $past(vec_a));

  assert_reserved_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(op) > 3'b100 && src_a == $past(src_a)) |-> vec_a == $past(vec_a));

  assert_add64_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'b000 && lane_sz == 2'b11) |->
      (result[63:0] == vec_a[63:0] + vec_b[63:0] &&
       result[127:64] == vec_a[127:64] + vec_b[127:64]));

  assert_sub8_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'b001 && lane_sz == 2'b00) |-> result[7:0] == vec_a[7:0] - vec_b[7:0]);

  assert_umax64_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'b011 && lane_sz == 2'b11 && !sgn) |->
      result[63:0] == ((vec_a[63:0] > vec_b[63:0]) ? vec_a[63:0] : vec_b[63:0]));
endmodule

bind vlane_alu_top vlane_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .lane_sz(lane_sz),
  .sgn(sgn), .src_a(src_a), .dst(dst), .imm(imm),
  .vec_a(vec_a), .vec_b(vec_b), .result(result)
);

// File: tb/sim_vlane_alu_top.sv
module sim_vlane_alu_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         issue;
  logic [2:0]   op;
  logic [1:0]   lane_sz;
  logic         sgn;
  logic [4:0]   src_a, src_b, dst;
  logic [127:0] imm;
  logic [127:0] vec_a, vec_b, result;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [127:0] model [32];

  always #5 clk = ~clk;

  vlane_alu_top u0 (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .lane_sz(lane_sz),
    .sgn(sgn), .src_a(src_a), .src_b(src_b), .dst(dst), .imm(imm),
    .vec_a(vec_a), .vec_b(vec_b), .result(result)
  );

  function automatic logic [127:0] ref_op(int o, int sz, bit sg,
                                          logic [127:0] a, logic [127:0] b);
    int w = 8 << sz;
    int n = 128 / w;
    logic [127:0] r = '0;
    logic [63:0] m = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
    for (int l = 0; l < n; l++) begin
      logic [63:0] x, y, z, bias;
      x = 64'(a >> (l * w)) & m;
      y = 64'(b >> (l * w)) & m;
      bias = sg ? (64'd1 << (w - 1)) : 64'd0;
      case (o)
        0: z = (x + y) & m;
        1: z = (x - y) & m;
        2: z = ((x ^ bias) < (y ^ bias)) ? x : y;
        default: z = ((x ^ bias) < (y ^ bias)) ? y : x;
      endcase
      r = r | (128'(z) << (l * w));
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit iss, int o, int sz, bit sg, int a_i, int b_i, int d_i,
                      logic [127:0] im, string tag);
    logic [127:0] exp_r;
    @(negedge clk);
    issue = iss; op = 3'(o); lane_sz = 2'(sz); sgn = sg;
    src_a = 5'(a_i); src_b = 5'(b_i); dst = 5'(d_i); imm = im;
    #1;
    chk(tag, vec_a, model[a_i]);
    chk(tag, vec_b, model[b_i]);
    exp_r = ref_op(o, sz, sg, model[a_i], model[b_i]);
    if (o < 4) chk(tag, result, exp_r);
    @(posedge clk);
    if (iss && o == 4) model[d_i] = im;
    else if (iss && o < 4) model[d_i] = exp_r;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #1_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; issue = 1'b0; op = '0; lane_sz = '0; sgn = 1'b0;
    src_a = '0; src_b = '0; dst = '0; imm = '0;
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: all registers zero after reset
    for (int i = 0; i < 32; i++) step(0, 0, 0, 0, i, 31 - i, 0, '0, "R1");

    // R2: load patterns
    step(1, 4, 0, 0, 0, 0, 1, {128{1'b1}}, "R2");
    step(1, 4, 0, 0, 1, 0, 2, {64{2'b01}} & {16{8'h01}}, "R2");
    step(1, 4, 0, 0, 2, 1, 3, {16{8'h80}}, "R2");
    step(1, 4, 0, 0, 3, 2, 4, {16{8'h7F}}, "R2");
    step(1, 4, 0, 0, 4, 3, 5, {8{16'h8001}}, "R2");
    step(1, 4, 0, 0, 5, 4, 6, {4{32'h7FFF_FFFF}}, "R2");
    for (int i = 7; i < 16; i++) step(1, 4, 0, 0, i - 1, i - 2, i, rnd128(), "R2");
    for (int i = 1; i < 16; i++) step(0, 0, 0, 0, i, i, 0, '0, "R2");

    // R3: write and read the same register in one cycle, then next cycle
    step(1, 4, 0, 0, 20, 20, 20, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, "R3");
    step(1, 0, 0, 0, 20, 1, 20, '0, "R3");
    step(0, 0, 0, 0, 20, 20, 0, '0, "R3");

    // R4..R8: every op, size and sign on edge and random operands
    for (int sz = 0; sz < 4; sz++)
      for (int sg = 0; sg < 2; sg++)
        for (int o = 0; o < 4; o++) begin
          string t;
          if (o == 0)      t = sg ? "R8" : "R4";
          else if (o == 1) t = sg ? "R8" : "R5";
          else             t = sg ? "R7" : "R6";
          step(1, o, sz, sg[0], 1, 2, 21, '0, t);   // all-ones with one
          step(1, o, sz, sg[0], 0, 2, 22, '0, t);   // zero minus one
          step(1, o, sz, sg[0], 3, 4, 23, '0, t);   // 0x80 vs 0x7F
          step(1, o, sz, sg[0], 5, 6, 24, '0, t);
          step(1, o, sz, sg[0], 7, 8, 25, '0, t);
          step(0, 0, 0, 0, 21, 22, 0, '0, t);
        end

    // R9: issue low does not write
    step(0, 4, 0, 0, 1, 2, 1, 128'hDEAD, "R9");
    step(0, 0, 3, 0, 1, 2, 2, '0, "R9");
    step(0, 0, 0, 0, 1, 2, 0, '0, "R9");

    // R10: reserved codes write nothing
    for (int o = 5; o < 8; o++) step(1, o, 0, 0, 3, 4, 3, 128'hBEEF, "R10");
    step(0, 0, 0, 0, 3, 4, 0, '0, "R10");

    // mixed random traffic
    for (int k = 0; k < 300; k++) begin
      int o = int'($urandom % 8);
      step(1'($urandom), o, int'($urandom % 4), 1'($urandom),
           int'($urandom % 32), int'($urandom % 32), int'($urandom % 32),
           rnd128(), o < 2 ? "R4" : (o < 4 ? "R6" : (o == 4 ? "R2" : "R10")));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule